// File: doc/BRIEF.md
# CAN Fault Confinement Status Unit

This unit keeps the transmit and receive error counts of a CAN controller and derives an 8-bit status word from them. The counts move one step for each increment or decrement strobe that the error-detection logic raises. When the transmit count reaches 256, the unit takes the node off the bus. It then watches the sampled bus level for the recovery sequence, and after that sequence it waits for software to finish re-initialisation before it lets the node back onto the bus.

The unit also has a warning flag whose threshold software selects, either 96 or 128. The edges that raise an interrupt depend on that selection. A wake-status flag follows the two low-power mode bits. Bus-off entry, warning changes and wake-up events all set one sticky interrupt-pending flag, gated by the interrupt enables.

A small host port has a write strobe and an address. Through it software writes the control register, acknowledges the interrupt and reads the status word and both error counts. Reads are combinational. Every state change takes effect on the clock edge that samples the causing input.

Top module: `can_fcs_unit`

## Requirements
- R1: When an increment brings the transmit count to 256, the same clock edge sets status bit 7 (off-bus), clears the software-init bit (control bit 0) and drives `bus_en` low.
- R2: The off-bus state ends only after 128 separate runs of 11 consecutive recessive samples (`bit_lvl`=1 with `bit_stb`), followed by one more 11-sample recessive run.
- R3: On the edge that completes the last run, status bit 7 clears, both counts become 0 and the software-init bit becomes 1. `bus_en` is high only while status bit 7 is 0 and the software-init bit is 0.
- R4: While status bit 7 is 1, host writes leave the software-init bit unchanged. The other control bits are still written.
- R5: A 0-to-1 change of status bit 7 sets the interrupt-pending flag only when the error enable (control bit 2), the module enable (bit 4) and the global enable (bit 5) are all 1.
- R6: With threshold select (control bit 1) at 0, status bit 6 is 1 whenever either count is 96 or more. Only its 0-to-1 change raises an interrupt.
- R7: With threshold select at 1, the threshold is 128, and both the 0-to-1 and the 1-to-0 change of status bit 6 raise an interrupt.
- R8: Status bit 5 is 1 while `siesta` or `pdown` is 1 and 0 when both are 0. Its 1-to-0 change raises an interrupt when the status enable (control bit 3), the module enable and the global enable are 1.
- R9: The status word is {off-bus, warning, wake, rx status, tx status, error code[2:0]} from bit 7 down to bit 0, and all of it resets to 0. A host write to address 0 changes only bits 4 and 3. `ecode_stb` loads `ecode_in` into bits 2:0.
- R10: A dominant sample resets the current run length to 0 and keeps the number of completed runs. Runs are counted only while off-bus.
- R11: Each strobe moves its count by one, and an increment with a decrement in the same cycle leaves the count unchanged. A count stays at 0 on decrement, the receive count stops at 255, and both counts hold while off-bus. Address 3 reads the transmit count bits 7:0, address 4 its bit 8, and address 5 the receive count.
- R12: The interrupt-pending flag drives `irq`, reads as bit 0 of address 2, and stays set until a write of 1 to bit 0 of address 2. A new event in the same cycle wins over the clear.
- R13: The control register at address 1 holds {global enable, module enable, status enable, error enable, threshold select, software-init} in bits 5 down to 0. It resets to 0 and reads back with bits 7:6 at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tec_inc | input | 1 | Transmit error count increment strobe |
| tec_dec | input | 1 | Transmit error count decrement strobe |
| rec_inc | input | 1 | Receive error count increment strobe |
| rec_dec | input | 1 | Receive error count decrement strobe |
| bit_stb | input | 1 | One pulse per sampled bus bit |
| bit_lvl | input | 1 | Sampled bus level, 1 = recessive |
| siesta | input | 1 | Light sleep mode bit |
| pdown | input | 1 | Power-down mode bit |
| ecode_stb | input | 1 | Loads a new error code |
| ecode_in | input | 3 | Error code value |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 3 | Host write address |
| wr_data | input | 8 | Host write data |
| rd_addr | input | 3 | Host read address |
| rd_data | output | 8 | Host read data (combinational) |
| status | output | 8 | Status word |
| bus_en | output | 1 | Node may transmit and receive |
| irq | output | 1 | Interrupt request (pending flag) |

## Verification
Every counter, flag and pending-interrupt result of this unit shows up on the clock edge that samples its strobe, bit sample, mode bit or host write. The read port is combinational. Each result is therefore due one edge after its stimulus. The driver applies every stimulus just after a rising edge and queues the expected value. The monitor pops and compares that value at the next falling edge, so it reads the output half a cycle after the update. The recovery test splits the recessive stream with dominant samples at chosen points, so an off-by-one in the run length or in the run count ends bus-off early or late and is caught.

// File: rtl/can_fcs_pkg.sv
package can_fcs_pkg;

    localparam int TEC_W     = 9;
    localparam int REC_W     = 8;
    localparam int TEC_LIMIT = 256;
    localparam int REC_MAX   = (1 << REC_W) - 1;
    localparam int WARN_LO   = 96;
    localparam int WARN_HI   = 128;
    localparam int ADDR_W    = 3;

    localparam logic [ADDR_W-1:0] A_STATUS = 3'd0;
    localparam logic [ADDR_W-1:0] A_CTRL   = 3'd1;
    localparam logic [ADDR_W-1:0] A_IRQ    = 3'd2;
    localparam logic [ADDR_W-1:0] A_TEC_LO = 3'd3;
    localparam logic [ADDR_W-1:0] A_TEC_HI = 3'd4;
    localparam logic [ADDR_W-1:0] A_REC    = 3'd5;

    // control register, bit 5 down to bit 0
    typedef struct packed {
        logic glb_ie;
        logic mod_ie;
        logic sts_ie;
        logic err_ie;
        logic thr_sel;
        logic swinit;
    } ctrl_t;

    // status word, bit 7 down to bit 0
    typedef struct packed {
        logic       offbus;
        logic       warn;
        logic       wake;
        logic       rxs;
        logic       txs;
        logic [2:0] ecode;
    } status_t;

    typedef enum logic [1:0] {
        PH_ONLINE  = 2'd0,
        PH_RECOVER = 2'd1,
        PH_POWERUP = 2'd2
    } phase_e;

    // one step of a saturating up/down counter
    function automatic logic [TEC_W-1:0] step_cnt(
        input logic [TEC_W-1:0] v,
        input logic             up,
        input logic             dn,
        input logic [TEC_W-1:0] ceil
    );
        logic [TEC_W-1:0] r;
        r = v;
        if (up && !dn)
            r = (v >= ceil) ? ceil : v + 1'b1;
        else if (dn && !up)
            r = (v == '0) ? v : v - 1'b1;
        return r;
    endfunction

    function automatic logic warn_hit(
        input logic [TEC_W-1:0] tec,
        input logic [TEC_W-1:0] rec,
        input logic             sel
    );
        logic [TEC_W-1:0] thr;
        thr = sel ? TEC_W'(WARN_HI) : TEC_W'(WARN_LO);
        return (tec >= thr) || (rec >= thr);
    endfunction

endpackage

// File: rtl/can_fcs_errcnt.sv
module can_fcs_errcnt
    import can_fcs_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tec_inc,
    input  logic             tec_dec,
    input  logic             rec_inc,
    input  logic             rec_dec,
    input  logic             hold,
    input  logic             wipe,
    output logic [TEC_W-1:0] tec_q,
    output logic [TEC_W-1:0] tec_n,
    output logic [REC_W-1:0] rec_q,
    output logic [REC_W-1:0] rec_n
);

    always_comb begin
        tec_n = tec_q;
        rec_n = rec_q;
        if (wipe) begin
            tec_n = '0;
            rec_n = '0;
        end else if (!hold) begin
            tec_n = step_cnt(tec_q, tec_inc, tec_dec, TEC_W'(TEC_LIMIT));
            rec_n = REC_W'(step_cnt(TEC_W'(rec_q), rec_inc, rec_dec,
                                    TEC_W'(REC_MAX)));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tec_q <= '0;
            rec_q <= '0;
        end else begin
            tec_q <= tec_n;
            rec_q <= rec_n;
        end
    end

endmodule

// File: rtl/can_fcs_recovery.sv
module can_fcs_recovery
    import can_fcs_pkg::*;
#(
    parameter int RUN_BITS  = 11,
    parameter int RUN_COUNT = 128
) (
    input  logic clk,
    input  logic rst,
    input  logic enter,
    input  logic bit_stb,
    input  logic bit_lvl,
    output logic offbus,
    output logic done
);

    localparam int LEN_W = $clog2(RUN_BITS);
    localparam int CNT_W = $clog2(RUN_COUNT + 1);

    phase_e           phase_q;
    logic [LEN_W-1:0] len_q;
    logic [CNT_W-1:0] runs_q;
    logic             run_end;

    assign run_end = bit_stb && bit_lvl && (len_q == LEN_W'(RUN_BITS - 1));
    assign done    = (phase_q == PH_POWERUP) && run_end;
    assign offbus  = (phase_q != PH_ONLINE);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_ONLINE;
            len_q   <= '0;
            runs_q  <= '0;
        end else if (enter) begin
            phase_q <= PH_RECOVER;
            len_q   <= '0;
            runs_q  <= '0;
        end else if (phase_q != PH_ONLINE && bit_stb) begin
            if (!bit_lvl) begin
                len_q <= '0;
            end else if (run_end) begin
                len_q <= '0;
                if (phase_q == PH_RECOVER) begin
                    if (runs_q == CNT_W'(RUN_COUNT - 1)) begin
                        runs_q  <= '0;
                        phase_q <= PH_POWERUP;
                    end else begin
                        runs_q <= runs_q + 1'b1;
                    end
                end else begin
                    phase_q <= PH_ONLINE;
                end
            end else begin
                len_q <= len_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/can_fcs_irq.sv
module can_fcs_irq
    import can_fcs_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  ctrl_t ctrl,
    input  logic  offbus_q,
    input  logic  offbus_n,
    input  logic  warn_q,
    input  logic  warn_n,
    input  logic  wake_q,
    input  logic  wake_n,
    input  logic  clr,
    output logic  pending
);

    logic gate, ev_off, ev_warn, ev_wake, set;

    assign gate    = ctrl.glb_ie && ctrl.mod_ie;
    assign ev_off  = ctrl.err_ie && offbus_n && !offbus_q;
    assign ev_warn = ctrl.err_ie &&
                     (ctrl.thr_sel ? (warn_n ^ warn_q) : (warn_n && !warn_q));
    assign ev_wake = ctrl.sts_ie && wake_q && !wake_n;
    assign set     = gate && (ev_off || ev_warn || ev_wake);

    always_ff @(posedge clk) begin
        if (rst)
            pending <= 1'b0;
        else if (set)
            pending <= 1'b1;
        else if (clr)
            pending <= 1'b0;
    end

endmodule

// File: rtl/can_fcs_unit.sv
module can_fcs_unit
    import can_fcs_pkg::*;
#(
    parameter int RUN_BITS  = 11,
    parameter int RUN_COUNT = 128
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tec_inc,
    input  logic       tec_dec,
    input  logic       rec_inc,
    input  logic       rec_dec,
    input  logic       bit_stb,
    input  logic       bit_lvl,
    input  logic       siesta,
    input  logic       pdown,
    input  logic       ecode_stb,
    input  logic [2:0] ecode_in,
    input  logic       wr_en,
    input  logic [2:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic [2:0] rd_addr,
    output logic [7:0] rd_data,
    output logic [7:0] status,
    output logic       bus_en,
    output logic       irq
);

    ctrl_t            ctrl_q;
    status_t          st;
    logic             offbus, done, enter, offbus_n;
    logic             warn_q, warn_n, wake_q, wake_n;
    logic             rxs_q, txs_q;
    logic [2:0]       ecode_q;
    logic [TEC_W-1:0] tec_q, tec_n;
    logic [REC_W-1:0] rec_q, rec_n;
    logic             irq_clr;

    can_fcs_errcnt u_cnt (
        .clk     (clk),
        .rst     (rst),
        .tec_inc (tec_inc),
        .tec_dec (tec_dec),
        .rec_inc (rec_inc),
        .rec_dec (rec_dec),
        .hold    (offbus),
        .wipe    (done),
        .tec_q   (tec_q),
        .tec_n   (tec_n),
        .rec_q   (rec_q),
        .rec_n   (rec_n)
    );

    assign enter    = !offbus && (tec_n == TEC_W'(TEC_LIMIT));
    assign offbus_n = enter || (offbus && !done);

    can_fcs_recovery #(
        .RUN_BITS  (RUN_BITS),
        .RUN_COUNT (RUN_COUNT)
    ) u_rcv (
        .clk     (clk),
        .rst     (rst),
        .enter   (enter),
        .bit_stb (bit_stb),
        .bit_lvl (bit_lvl),
        .offbus  (offbus),
        .done    (done)
    );

    assign warn_n  = warn_hit(tec_n, TEC_W'(rec_n), ctrl_q.thr_sel);
    assign wake_n  = siesta || pdown;
    assign irq_clr = wr_en && (wr_addr == A_IRQ) && wr_data[0];

    can_fcs_irq u_irq (
        .clk      (clk),
        .rst      (rst),
        .ctrl     (ctrl_q),
        .offbus_q (offbus),
        .offbus_n (offbus_n),
        .warn_q   (warn_q),
        .warn_n   (warn_n),
        .wake_q   (wake_q),
        .wake_n   (wake_n),
        .clr      (irq_clr),
        .pending  (irq)
    );

    // control register with software-init handshake
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else begin
            if (wr_en && wr_addr == A_CTRL) begin
                ctrl_q.glb_ie  <= wr_data[5];
                ctrl_q.mod_ie  <= wr_data[4];
                ctrl_q.sts_ie  <= wr_data[3];
                ctrl_q.err_ie  <= wr_data[2];
                ctrl_q.thr_sel <= wr_data[1];
                if (!offbus)
                    ctrl_q.swinit <= wr_data[0];
            end
            if (enter)
                ctrl_q.swinit <= 1'b0;
            else if (done)
                ctrl_q.swinit <= 1'b1;
        end
    end

    // status flags
    always_ff @(posedge clk) begin
        if (rst) begin
            warn_q  <= 1'b0;
            wake_q  <= 1'b0;
            rxs_q   <= 1'b0;
            txs_q   <= 1'b0;
            ecode_q <= '0;
        end else begin
            warn_q <= warn_n;
            wake_q <= wake_n;
            if (wr_en && wr_addr == A_STATUS) begin
                rxs_q <= wr_data[4];
                txs_q <= wr_data[3];
            end
            if (ecode_stb)
                ecode_q <= ecode_in;
        end
    end

    always_comb begin
        st.offbus = offbus;
        st.warn   = warn_q;
        st.wake   = wake_q;
        st.rxs    = rxs_q;
        st.txs    = txs_q;
        st.ecode  = ecode_q;
    end

    assign status = st;
    assign bus_en = !offbus && !ctrl_q.swinit;

    always_comb begin
        case (rd_addr)
            A_STATUS: rd_data = st;
            A_CTRL:   rd_data = {2'b00, ctrl_q};
            A_IRQ:    rd_data = {7'b0, irq};
            A_TEC_LO: rd_data = tec_q[7:0];
            A_TEC_HI: rd_data = 8'(tec_q >> 8);
            A_REC:    rd_data = rec_q;
            default:  rd_data = 8'h00;
        endcase
    end

endmodule

// File: rtl/can_fcs_chk.sv
module can_fcs_chk (
    input logic clk,
    input logic rst,
    input logic offbus,
    input logic wake,
    input logic wake_req,
    input logic rec_bit,
    input logic bus_en,
    input logic irq,
    input logic irq_clr
);

    // R1: off-bus always keeps the node off the bus
    p_offbus_blocks_bus_r1: assert property (@(posedge clk) disable iff (rst)
        offbus |-> !bus_en);

    // R2: leaving off-bus needs a recessive sample on that edge
    p_exit_on_recessive_r2: assert property (@(posedge clk) disable iff (rst)
        $fell(offbus) |-> $past(rec_bit));

    // R3: after exit the software-init handshake still blocks the bus
    p_exit_waits_swinit_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(offbus) |-> !bus_en);

    // R8: wake flag follows the low-power bits one edge later
    p_wake_tracks_r8: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (wake == $past(wake_req)));

    // R12: pending interrupt holds until it is cleared
    p_irq_sticky_r12: assert property (@(posedge clk) disable iff (rst)
        (irq && !irq_clr) |=> irq);

endmodule

bind can_fcs_unit can_fcs_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .offbus   (status[7]),
    .wake     (status[5]),
    .wake_req (siesta | pdown),
    .rec_bit  (bit_stb & bit_lvl),
    .bus_en   (bus_en),
    .irq      (irq),
    .irq_clr  (wr_en && (wr_addr == 3'd2) && wr_data[0])
);

// File: tb/sim_can_fcs_unit.sv
`timescale 1ns/1ps
module sim_can_fcs_unit;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tec_inc = 0, tec_dec = 0, rec_inc = 0, rec_dec = 0;
    logic       bit_stb = 0, bit_lvl = 0, siesta = 0, pdown = 0;
    logic       ecode_stb = 0;
    logic [2:0] ecode_in = '0;
    logic       wr_en = 0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data, status;
    logic       bus_en, irq;

    always #2 clk = ~clk;

    can_fcs_unit u0 (
        .clk(clk), .rst(rst),
        .tec_inc(tec_inc), .tec_dec(tec_dec), .rec_inc(rec_inc), .rec_dec(rec_dec),
        .bit_stb(bit_stb), .bit_lvl(bit_lvl), .siesta(siesta), .pdown(pdown),
        .ecode_stb(ecode_stb), .ecode_in(ecode_in),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .status(status), .bus_en(bus_en), .irq(irq)
    );

    typedef struct {
        int         src;   // 0 read port, 1 status, 2 irq, 3 bus_en
        logic [2:0] addr;
        logic [8:0] exp;
        string      req;
    } item_t;

    item_t sbq[$];
    int    n_chk  = 0;
    int    n_fail = 0;
    bit    fin    = 0;

    // monitor: pops expected items half a cycle after the update edge
    always @(negedge clk) begin
        if (sbq.size() > 0) begin
            item_t      it;
            logic [8:0] act;
            it = sbq.pop_front();
            case (it.src)
                0:       act = {1'b0, rd_data};
                1:       act = {1'b0, status};
                2:       act = {8'b0, irq};
                default: act = {8'b0, bus_en};
            endcase
            n_chk++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s: actual %0h expected %0h", it.req, act, it.exp);
            end
        end
    end

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic push(input int src, input logic [2:0] a,
                        input logic [8:0] v, input string req);
        item_t it;
        rd_addr = a;
        it.src = src; it.addr = a; it.exp = v; it.req = req;
        sbq.push_back(it);
        @(negedge clk); #1;
    endtask

    task automatic chk_reg(input logic [2:0] a, input logic [7:0] v, input string r);
        push(0, a, {1'b0, v}, r);
    endtask
    task automatic chk_sts(input logic [7:0] v, input string r);
        push(1, 3'd0, {1'b0, v}, r);
    endtask
    task automatic chk_irq(input logic v, input string r);
        push(2, 3'd0, {8'b0, v}, r);
    endtask
    task automatic chk_bus(input logic v, input string r);
        push(3, 3'd0, {8'b0, v}, r);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        wr_en = 1; wr_addr = a; wr_data = d; tick(); wr_en = 0;
    endtask
    task automatic tec_up(input int n);
        tec_inc = 1; repeat (n) tick(); tec_inc = 0;
    endtask
    task automatic rec_up(input int n);
        rec_inc = 1; repeat (n) tick(); rec_inc = 0;
    endtask
    task automatic rec_down(input int n);
        rec_dec = 1; repeat (n) tick(); rec_dec = 0;
    endtask
    task automatic bits(input int n, input logic lvl);
        bit_stb = 1; bit_lvl = lvl; repeat (n) tick(); bit_stb = 0;
    endtask

    initial begin
        repeat (10000) @(posedge clk);
        if (!fin) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst = 0;
        tick();
        chk_sts(8'h00, "R9 status reset");
        chk_reg(3'd1, 8'h00, "R13 control reset");
        chk_irq(0, "R12 irq reset");
        chk_bus(1, "R3 bus enabled after reset");

        wr(3'd1, 8'h3C);
        chk_reg(3'd1, 8'h3C, "R13 control readback");
        wr(3'd0, 8'hFF);
        chk_sts(8'h18, "R9 only rx/tx writable");
        ecode_in = 3'd5; ecode_stb = 1; tick(); ecode_stb = 0;
        chk_sts(8'h1D, "R9 error code load");
        wr(3'd0, 8'h00);
        chk_sts(8'h05, "R9 rx/tx cleared");

        // threshold 96
        rec_up(95);
        chk_reg(3'd5, 8'd95, "R11 receive count");
        chk_sts(8'h05, "R6 below 96");
        chk_irq(0, "R6 no irq below 96");
        rec_up(1);
        chk_sts(8'h45, "R6 warn at 96");
        chk_irq(1, "R6 rise irq");
        wr(3'd2, 8'h01);
        chk_irq(0, "R12 write-one clear");
        rec_inc = 1; rec_dec = 1; tick(); rec_inc = 0; rec_dec = 0;
        chk_reg(3'd5, 8'd96, "R11 inc with dec");
        rec_down(1);
        chk_sts(8'h05, "R6 warn falls");
        chk_irq(0, "R6 no irq on fall");
        rec_down(100);
        chk_reg(3'd5, 8'd0, "R11 floor at zero");

        // threshold 128
        wr(3'd1, 8'h3E);
        rec_up(127);
        chk_sts(8'h05, "R7 no warn below 128");
        chk_irq(0, "R7 no irq below 128");
        rec_up(1);
        chk_sts(8'h45, "R7 warn at 128");
        chk_irq(1, "R7 rise irq");
        wr(3'd2, 8'h01);
        rec_down(1);
        chk_sts(8'h05, "R7 warn falls");
        chk_irq(1, "R7 fall irq");
        wr(3'd2, 8'h01);
        rec_down(200);

        // wake status
        siesta = 1; tick();
        chk_sts(8'h25, "R8 siesta sets wake");
        pdown = 1; tick(); siesta = 0; tick();
        chk_sts(8'h25, "R8 pdown holds wake");
        chk_irq(0, "R8 no irq while asleep");
        pdown = 0; tick();
        chk_sts(8'h05, "R8 wake clears");
        chk_irq(1, "R8 wake fall irq");
        wr(3'd2, 8'h01);
        wr(3'd1, 8'h1E);
        siesta = 1; tick(); siesta = 0; tick();
        chk_irq(0, "R5 global enable gates irq");

        // bus-off entry
        wr(3'd1, 8'h3F);
        chk_bus(0, "R3 swinit blocks bus");
        tec_up(255);
        chk_reg(3'd3, 8'hFF, "R11 transmit count low");
        chk_reg(3'd4, 8'h00, "R11 transmit count high");
        wr(3'd2, 8'h01);
        tec_up(1);
        chk_sts(8'hC5, "R1 off-bus set");
        chk_reg(3'd4, 8'h01, "R11 transmit count 256");
        chk_reg(3'd1, 8'h3E, "R1 swinit cleared on entry");
        chk_bus(0, "R1 bus disabled");
        chk_irq(1, "R5 off-bus irq");
        wr(3'd2, 8'h01);
        wr(3'd1, 8'h3F);
        chk_reg(3'd1, 8'h3E, "R4 swinit write ignored");
        rec_up(5);
        chk_reg(3'd5, 8'd0, "R11 counts hold off-bus");

        // recovery
        bits(10, 1); bits(1, 0);
        bits(128 * 11, 1);
        bits(10, 1);
        chk_sts(8'hC5, "R2 still off-bus before power-up run");
        bits(1, 0);
        bits(10, 1);
        chk_sts(8'hC5, "R10 dominant restarts run");
        bits(1, 1);
        chk_sts(8'h05, "R3 off-bus cleared");
        chk_reg(3'd1, 8'h3F, "R3 swinit set on exit");
        chk_reg(3'd3, 8'h00, "R3 transmit count wiped");
        chk_reg(3'd4, 8'h00, "R3 transmit count high wiped");
        chk_bus(0, "R3 bus waits for swinit");
        chk_irq(1, "R7 warn fall on exit");
        wr(3'd1, 8'h3E);
        chk_bus(1, "R3 bus resumes");

        fin = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule